// File: doc/BRIEF.md
# Programmable Video Frame Timing Counter

This block keeps track of where a video display channel is in its raster. A pixel counter advances once for each cycle with the pixel enable high. A line counter advances each time the pixel counter wraps. Each cycle, the block reports the current position and marks the last pixel of a line and the last pixel of a frame.

The dimensions of a frame are set through one 32-bit frame-size register. The register holds the total pixels per line and the total lines per frame, blanking included. Software writes the register at any time. The block copies it into an active copy only between frames, so a frame already under way is never cut short. If either dimension is zero, the channel is treated as switched off.

Top module: `vrt_raster_timer`

## Requirements
- R1: Writing the frame-size register stores the line total from bits 27:16 and the pixel total from bits 11:0. Each field is 12 bits. `reg_rdata` returns both fields at the same bit positions in the cycle after the write.
- R2: Bits 31:28 and 15:12 of `reg_rdata` always read as 0. Data written to those bits changes nothing.
- R3: When the synchronous reset `rst` is high at a clock edge, both fields are cleared to 0, `pix_cnt` becomes 0 and `line_cnt` becomes 1. No strobe is produced until a nonzero size is programmed.
- R4: With active width W and `pix_en` high, `pix_cnt` steps 0, 1, …, W−1 and then returns to 0 on the following step.
- R5: With active height H, `line_cnt` runs from 1 to H and then returns to 1. It changes only on a step in which the pixel counter wraps.
- R6: `eol` is high in a cycle where `pix_en` is high and `pix_cnt` equals W−1. `eof` is high when `eol` is high and `line_cnt` also equals H.
- R7: While `pix_en` is low, `pix_cnt` and `line_cnt` hold their values and neither strobe is produced.
- R8: An active width or height of 0 disables the channel. `pix_cnt` is held at 0 and `line_cnt` at 1, and `eol` and `eof` stay low whatever `pix_en` does.
- R9: A programmed size becomes active in one of two ways. While the channel runs, it takes effect on the step that completes a frame, marked by `eof`. While the channel is disabled, it takes effect at the first clock edge after the register holds it. The rest of the current frame runs with the old size.
- R10: A width of 1 keeps `pix_cnt` at 0 and produces `eol` on every enabled step. A size of 1×1 also produces `eof` on every enabled step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr_en | input | 1 | Write strobe for the frame-size register |
| reg_wdata | input | 32 | Write data: line total in bits 27:16, pixel total in bits 11:0 |
| reg_rdata | output | 32 | Programmed frame size; reserved bits read as 0 |
| pix_en | input | 1 | Pixel clock enable; one counter step per high cycle |
| pix_cnt | output | 12 | Current pixel position, zero-based |
| line_cnt | output | 12 | Current line number, one-based |
| eol | output | 1 | High on the step at the last pixel of a line |
| eof | output | 1 | High on the step at the last pixel of a frame |

## Verification
The assertions check the following on every cycle:
- the counters stay inside the active dimensions;
- the pixel counter steps by one, or wraps to 0 after `eol`;
- the line counter moves only on a wrap and returns to 1 after `eof`;
- both counters freeze while the enable is low;
- a disabled channel holds its start values;
- the active size changes only at a frame boundary or while disabled.

Only the bench's scenarios can show the rest:
- the register layout and the masking of reserved bits;
- the exact length of a line at the standard-definition widths;
- a size written in the middle of a frame leaves that frame's length unchanged.

// File: rtl/vrt_pkg.sv
package vrt_pkg;
    localparam int unsigned DIM_W      = 12;
    localparam int unsigned REG_W      = 32;
    localparam int unsigned PIX_LSB    = 0;
    localparam int unsigned LINE_LSB   = 16;

    typedef logic [DIM_W-1:0] dim_t;

    typedef struct packed {
        dim_t lines;
        dim_t pixels;
    } frame_dims_t;
endpackage

// File: rtl/vrt_size_reg.sv
module vrt_size_reg
    import vrt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             frame_done,
    output logic [REG_W-1:0] rdata,
    output frame_dims_t      act_dims,
    output logic             chan_on
);
    localparam logic [REG_W-1:0] FIELD_MASK =
        ({{(REG_W-DIM_W){1'b0}}, {DIM_W{1'b1}}} << PIX_LSB) |
        ({{(REG_W-DIM_W){1'b0}}, {DIM_W{1'b1}}} << LINE_LSB);

    typedef struct packed {
        frame_dims_t prog;
        frame_dims_t act;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;
    logic       reload;
    logic       unused_rsvd;

    assign chan_on     = (cfg_q.act.pixels != '0) && (cfg_q.act.lines != '0);
    assign reload      = !chan_on || frame_done;
    assign unused_rsvd = ^(wdata & ~FIELD_MASK);

    always_comb begin
        cfg_d = cfg_q;
        if (reload) begin
            cfg_d.act = cfg_q.prog;
        end
        if (wr_en) begin
            cfg_d.prog.lines  = wdata[LINE_LSB +: DIM_W];
            cfg_d.prog.pixels = wdata[PIX_LSB  +: DIM_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rdata                      = '0;
        rdata[LINE_LSB +: DIM_W]   = cfg_q.prog.lines;
        rdata[PIX_LSB  +: DIM_W]   = cfg_q.prog.pixels;
    end

    assign act_dims = cfg_q.act;
endmodule

// File: rtl/vrt_axis_counter.sv
module vrt_axis_counter #(
    parameter int unsigned CW    = 12,
    parameter int unsigned START = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold_start,
    input  logic          step,
    input  logic [CW-1:0] limit,
    output logic [CW-1:0] cnt,
    output logic          at_end
);
    localparam logic [CW-1:0] START_V = CW'(START);
    localparam logic [CW-1:0] END_ADJ = CW'(1 - START);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_state_t;

    ctr_state_t ctr_d, ctr_q;
    logic [CW-1:0] end_val;

    assign end_val = limit - END_ADJ;
    assign at_end  = (ctr_q.cnt == end_val);

    always_comb begin
        ctr_d = ctr_q;
        if (hold_start) begin
            ctr_d.cnt = START_V;
        end else if (step) begin
            ctr_d.cnt = at_end ? START_V : ctr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_q.cnt <= START_V;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign cnt = ctr_q.cnt;
endmodule

// File: rtl/vrt_raster_timer.sv
module vrt_raster_timer
    import vrt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             pix_en,
    output logic [DIM_W-1:0] pix_cnt,
    output logic [DIM_W-1:0] line_cnt,
    output logic             eol,
    output logic             eof
);
    frame_dims_t act_dims;
    logic        chan_on;
    logic        pix_step;
    logic        pix_last;
    logic        line_last;

    assign pix_step = pix_en && chan_on;
    assign eol      = pix_step && pix_last;
    assign eof      = eol && line_last;

    vrt_size_reg u_size (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr_en),
        .wdata      (reg_wdata),
        .frame_done (eof),
        .rdata      (reg_rdata),
        .act_dims   (act_dims),
        .chan_on    (chan_on)
    );

    vrt_axis_counter #(.CW(DIM_W), .START(0)) u_pix (
        .clk        (clk),
        .rst        (rst),
        .hold_start (!chan_on),
        .step       (pix_step),
        .limit      (act_dims.pixels),
        .cnt        (pix_cnt),
        .at_end     (pix_last)
    );

    vrt_axis_counter #(.CW(DIM_W), .START(1)) u_line (
        .clk        (clk),
        .rst        (rst),
        .hold_start (!chan_on),
        .step       (eol),
        .limit      (act_dims.lines),
        .cnt        (line_cnt),
        .at_end     (line_last)
    );
endmodule

// File: rtl/vrt_raster_checker.sv
module vrt_raster_checker
    import vrt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             pix_en,
    input logic [DIM_W-1:0] pix_cnt,
    input logic [DIM_W-1:0] line_cnt,
    input logic             eol,
    input logic             eof,
    input logic             chan_on,
    input frame_dims_t      act_dims
);
    AST_PIX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        chan_on |-> (pix_cnt < act_dims.pixels)); // R4

    AST_LINE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        chan_on |-> (line_cnt != '0 && line_cnt <= act_dims.lines)); // R5

    AST_PIX_STEP: assert property (@(posedge clk) disable iff (rst)
        (pix_en && chan_on && !eol) |=> (pix_cnt == $past(pix_cnt) + 1'b1)); // R4

    AST_PIX_WRAP: assert property (@(posedge clk) disable iff (rst)
        eol |=> (pix_cnt == '0)); // R4

    AST_LINE_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        (chan_on && !eol) |=> $stable(line_cnt)); // R5

    AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
        (eol && !eof) |=> (line_cnt == $past(line_cnt) + 1'b1)); // R5

    AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (rst)
        eof |=> (line_cnt == 12'd1 && pix_cnt == '0)); // R5

    AST_EOF_NEEDS_EOL: assert property (@(posedge clk) disable iff (rst)
        eof |-> eol); // R6

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> ($stable(pix_cnt) && $stable(line_cnt))); // R7

    AST_DISABLED_START: assert property (@(posedge clk) disable iff (rst)
        !chan_on |-> (pix_cnt == '0 && line_cnt == 12'd1 && !eol && !eof)); // R8

    AST_SIZE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (chan_on && !eof) |=> $stable(act_dims)); // R9
endmodule

bind vrt_raster_timer vrt_raster_checker u_chk (.*);

// File: tb/vrt_raster_timer_test.sv
`timescale 1ns/1ps
module vrt_raster_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pix_en = 1'b0;
    logic [11:0] pix_cnt, line_cnt;
    logic        eol, eof;

    always #2.5 clk = ~clk;

    vrt_raster_timer uut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pix_en(pix_en), .pix_cnt(pix_cnt),
        .line_cnt(line_cnt), .eol(eol), .eof(eof)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference state derived from the requirements
    logic [11:0] mp = 12'd0, ml = 12'd1, mw = '0, mh = '0, pw = '0, ph = '0;
    logic        last_eol, last_eof;
    int          eol_seen = 0, eof_seen = 0;

    // {write data, expected read-back}
    localparam logic [63:0] REG_VEC [7] = '{
        {32'h0000_0000, 32'h0000_0000},
        {32'hFFFF_FFFF, 32'h0FFF_0FFF},
        {32'h020D_035A, 32'h020D_035A},
        {32'h0271_0360, 32'h0271_0360},
        {32'hF20D_F35A, 32'h020D_035A},
        {32'h0ABC_0123, 32'h0ABC_0123},
        {32'h5000_A000, 32'h0000_0000}
    };

    task automatic check(input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic tick(input logic en, input logic wr, input logic [31:0] wd,
                        input logic r);
        logic mon, e_eol, e_eof;
        pix_en = en; reg_wr_en = wr; reg_wdata = wd; rst = r;
        #1;
        mon   = (mw != 0) && (mh != 0);
        e_eol = mon && en && (mp == mw - 12'd1);
        e_eof = e_eol && (ml == mh);
        check(pix_cnt == mp,  "R4 pix_cnt",  {20'd0, pix_cnt},  {20'd0, mp});
        check(line_cnt == ml, "R5 line_cnt", {20'd0, line_cnt}, {20'd0, ml});
        check(eol == e_eol,   "R6 eol",      {31'd0, eol},      {31'd0, e_eol});
        check(eof == e_eof,   "R6 eof",      {31'd0, eof},      {31'd0, e_eof});
        check(reg_rdata == {4'd0, ph, 4'd0, pw}, "R1 rdata", reg_rdata, {4'd0, ph, 4'd0, pw});
        last_eol = eol; last_eof = eof;
        if (eol) eol_seen++;
        if (eof) eof_seen++;
        if (r) begin
            mp = 0; ml = 1; mw = 0; mh = 0; pw = 0; ph = 0;
        end else begin
            if (!mon) begin
                mp = 0; ml = 1;
            end else if (en) begin
                if (e_eol) begin
                    mp = 0;
                    ml = e_eof ? 12'd1 : ml + 12'd1;
                end else begin
                    mp = mp + 12'd1;
                end
            end
            if (!mon || e_eof) begin mw = pw; mh = ph; end
            if (wr) begin pw = wd[11:0]; ph = wd[27:16]; end
        end
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_vec++; n_bad++;
        $display("FAIL watchdog R3 actual=%0h expected=%0h", 0, 1);
        finish_run();
    end

    initial begin
        logic [11:0] held_p, held_l, pmax;
        int k, base_eol, base_eof, steps;
        @(posedge clk); @(posedge clk); #1;

        // R3 reset state
        check(pix_cnt == 0,  "R3 pix after reset",  {20'd0, pix_cnt},  0);
        check(line_cnt == 1, "R3 line after reset", {20'd0, line_cnt}, 1);
        check(reg_rdata == 0, "R3 rdata after reset", reg_rdata, 0);
        check(!eol && !eof,  "R3 strobes after reset", {30'd0, eol, eof}, 0);

        // R1 R2 register table
        foreach (REG_VEC[i]) begin
            tick(1'b0, 1'b1, REG_VEC[i][63:32], 1'b0);
            check(reg_rdata == REG_VEC[i][31:0], "R1 R2 readback",
                  reg_rdata, REG_VEC[i][31:0]);
            check(reg_rdata[31:28] == 0 && reg_rdata[15:12] == 0, "R2 reserved",
                  reg_rdata, REG_VEC[i][31:0]);
        end
        tick(1'b0, 1'b0, 0, 1'b1);

        // R8 width zero, then height zero
        tick(1'b0, 1'b1, 32'h0003_0000, 1'b0);
        base_eol = eol_seen;
        for (int i = 0; i < 20; i++) tick(1'b1, 1'b0, 0, 1'b0);
        check(eol_seen == base_eol, "R8 no eol width0", eol_seen - base_eol, 0);
        check(pix_cnt == 0 && line_cnt == 1, "R8 held width0", {pix_cnt, line_cnt}, {12'd0, 12'd1});
        tick(1'b0, 1'b1, 32'h0000_0005, 1'b0);
        for (int i = 0; i < 20; i++) tick(1'b1, 1'b0, 0, 1'b0);
        check(eol_seen == base_eol, "R8 no eol height0", eol_seen - base_eol, 0);
        check(pix_cnt == 0 && line_cnt == 1, "R8 held height0", {pix_cnt, line_cnt}, {12'd0, 12'd1});

        // R10 1x1
        tick(1'b0, 1'b1, 32'h0001_0001, 1'b0);
        tick(1'b0, 1'b0, 0, 1'b0);
        base_eol = eol_seen; base_eof = eof_seen;
        for (int i = 0; i < 6; i++) tick(1'b1, 1'b0, 0, 1'b0);
        check(eol_seen - base_eol == 6, "R10 eol each step", eol_seen - base_eol, 6);
        check(eof_seen - base_eof == 6, "R10 eof each step", eof_seen - base_eof, 6);

        // R9 zero size written while running waits for the frame end
        tick(1'b0, 1'b1, 32'h0000_0000, 1'b0);
        tick(1'b0, 1'b0, 0, 1'b0);
        base_eol = eol_seen;
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, 0, 1'b0);
        check(eol_seen - base_eol == 1, "R9 old frame finishes", eol_seen - base_eol, 1);

        // R4 R5 R6 R7 4x3 frames with gapped enable
        tick(1'b0, 1'b0, 0, 1'b1);
        tick(1'b0, 1'b1, 32'h0003_0004, 1'b0);
        tick(1'b0, 1'b0, 0, 1'b0);
        base_eol = eol_seen; base_eof = eof_seen; steps = 0;
        for (int i = 0; i < 60; i++) begin
            logic en;
            en = (i % 3) != 2;
            if (en) steps++;
            tick(en, 1'b0, 0, 1'b0);
        end
        check(eol_seen - base_eol == steps / 4, "R6 eol count", eol_seen - base_eol, steps / 4);
        check(eof_seen - base_eof == steps / 12, "R6 eof count", eof_seen - base_eof, steps / 12);
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, 0, 1'b0);
        held_p = pix_cnt; held_l = line_cnt; base_eol = eol_seen;
        for (int i = 0; i < 6; i++) tick(1'b0, 1'b0, 0, 1'b0);
        check(pix_cnt == held_p && line_cnt == held_l, "R7 hold",
              {pix_cnt, line_cnt}, {held_p, held_l});
        check(eol_seen == base_eol, "R7 no strobe while idle", eol_seen - base_eol, 0);

        // R9 mid-frame write of 525x858 (reserved bits set too)
        tick(1'b1, 1'b1, 32'hF20D_F35A, 1'b0);
        pmax = 0; k = 0;
        while (!last_eof && k < 20) begin
            if (pix_cnt > pmax) pmax = pix_cnt;
            tick(1'b1, 1'b0, 0, 1'b0);
            k++;
        end
        check(last_eof == 1'b1, "R9 frame end reached", {31'd0, last_eof}, 1);
        check(pmax <= 3, "R9 old width kept", {20'd0, pmax}, 3);
        for (int ln = 2; ln <= 3; ln++) begin
            k = 0;
            do begin tick(1'b1, 1'b0, 0, 1'b0); k++; end while (!last_eol && k < 1000);
            check(k == 858, "R4 line length 858", k, 858);
            check(line_cnt == 12'(ln), "R5 line advance", {20'd0, line_cnt}, ln);
        end

        // R3 reset mid-run, then 625x864 applies at once
        tick(1'b1, 1'b0, 0, 1'b1);
        check(pix_cnt == 0 && line_cnt == 1 && reg_rdata == 0, "R3 reset mid-run",
              {8'd0, pix_cnt, line_cnt}, {8'd0, 12'd0, 12'd1});
        tick(1'b0, 1'b1, 32'h0271_0360, 1'b0);
        tick(1'b0, 1'b0, 0, 1'b0);
        k = 0;
        do begin tick(1'b1, 1'b0, 0, 1'b0); k++; end while (!last_eol && k < 1000);
        check(k == 864, "R4 line length 864", k, 864);
        check(line_cnt == 2 && pix_cnt == 0, "R5 second line of 625",
              {pix_cnt, line_cnt}, {12'd0, 12'd2});

        finish_run();
    end
endmodule